// File: doc/BRIEF.md
# Reference-Switch Phase Realignment Controller

This block supervises a digital PLL while it changes from one input reference to another. Every selected reference pulse normally produces a virtual reference pulse for the phase detector. That pulse is delayed by a fixed pipeline bias plus a stored signed offset. When the reference selection changes, the controller puts the PLL into holdover. It waits for the first pulse of the newly chosen reference and counts sample-clock ticks from there to the next pulse of the PLL output feedback. From that count it derives a phase error.

The error is added to the stored offset, and the result saturates instead of wrapping. The virtual reference then lands where the PLL output already is, so the output does not jump. The controller then returns the PLL to normal tracking and raises a one-cycle completion flag. Because the offset carries over from one switch to the next, the delay it represents accumulates across switches.

A level-sensitive realign request clears the stored offset. This happens at the first selected reference pulse while the request is high, which snaps the output onto that reference edge. Slave mode behaves as if the request were held high permanently. Reference and feedback inputs are single-cycle pulses that are already synchronous to the sample clock.

Top module: `phase_realign_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go to zero after that edge: `holdover`, `virt_ref`, `switch_done` and `phase_offset`. The stored selection returns to input 0.
- R2: In tracking, when `ref_sel` differs from the stored selection at a clock edge, `holdover` is high from the next cycle. It stays high until the switch completes.
- R3: After a switch starts, the count C is the number of clock edges from the edge that samples the new reference's first pulse to the edge that samples the next `fb_pulse`. C saturates at 2^CNT_W-1. The captured error is C-(BIAS+old offset), where BIAS = 2^(ACC_W-1)-1. The new offset is the old offset plus that error.
- R4: The stored offset saturates at +/-(2^(ACC_W-1)-1) and never wraps.
- R5: `switch_done` is high for exactly the first cycle in which `holdover` is low again. The new offset is already visible in that cycle.
- R6: In tracking, a selected reference pulse sampled at edge t makes `virt_ref` high for the single cycle after edge t+BIAS+offset+1. Pulses on unselected inputs have no effect. A new selected pulse replaces a pending one.
- R7: `virt_ref` stays low during holdover, and a pulse pending when the switch starts is dropped.
- R8: With `realign_req` high, the first selected reference pulse sampled in tracking sets the offset to 0. That pulse's virtual reference uses a delay of BIAS alone.
- R9: With `slave_mode` high, the block acts as if `realign_req` were held. A switch that completes in slave mode stores offset 0.
- R10: Changes of `ref_sel` during holdover are ignored until the switch completes. A selection that still differs then starts a new switch in the next cycle.
- R11: A `fb_pulse` sampled on the same edge as the new reference's first pulse is not used. Measurement ends on a later feedback pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | N_REF | One pulse line per candidate reference |
| ref_sel | input | SEL_W | Requested reference index |
| fb_pulse | input | 1 | PLL output feedback pulse |
| slave_mode | input | 1 | Slave operation, keeps realignment active |
| realign_req | input | 1 | Level realign request |
| holdover | output | 1 | PLL holdover command |
| virt_ref | output | 1 | Virtual reference pulse to the phase detector |
| switch_done | output | 1 | One-cycle end-of-switch flag |
| phase_offset | output | ACC_W | Stored signed offset in sample ticks |

## Verification
On every cycle the assertions check several properties. The offset never exceeds its saturation limit. The virtual reference is silent during holdover and never lasts more than one cycle. The completion flag appears only as holdover drops. A realign at a reference pulse leaves a zero offset, and the stored selection is frozen while a switch is in progress. Other behaviours only show up in the bench's scenarios, because they depend on numbers that span hundreds of cycles. These are the exact offset produced by each measurement and its accumulation over successive switches, saturation at the positive limit, a feedback pulse that coincides with the reference pulse being skipped, a selection change deferred until the end of a switch, and slave mode forcing a zero offset.

// File: rtl/phr_pkg.sv
package phr_pkg;

    parameter int DEF_ACC_W = 8;
    parameter int DEF_CNT_W = 10;
    parameter int DEF_N_REF = 4;

    typedef enum logic [1:0] {
        ST_TRACK,
        ST_WAIT_EDGE,
        ST_MEASURE
    } sw_state_e;

    typedef struct packed {
        logic hold;
        logic start;
        logic done;
    } seq_status_s;

    function automatic int clamp_sym(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/phr_switch_seq.sv
module phr_switch_seq
    import phr_pkg::*;
#(
    parameter int N_REF = DEF_N_REF,
    parameter int SEL_W = 2,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ref_sel,
    input  logic [N_REF-1:0] ref_pulse,
    input  logic             fb_pulse,
    output logic             sel_edge,
    output seq_status_s      stat,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_ticks
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    sw_state_e        state;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;
    logic             done_q;

    always_comb begin
        sel_edge   = (int'(sel_q) < N_REF) && ref_pulse[sel_q];
        stat.hold  = (state != ST_TRACK);
        stat.start = (state == ST_TRACK) && (ref_sel != sel_q);
        stat.done  = done_q;
        meas_valid = (state == ST_MEASURE) && fb_pulse;
        meas_ticks = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_TRACK;
            sel_q  <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_TRACK: begin
                    if (stat.start) begin
                        sel_q <= ref_sel;
                        state <= ST_WAIT_EDGE;
                    end
                end
                ST_WAIT_EDGE: begin
                    if (sel_edge) begin
                        cnt   <= CNT_W'(1);
                        state <= ST_MEASURE;
                    end
                end
                ST_MEASURE: begin
                    if (fb_pulse) begin
                        state  <= ST_TRACK;
                        done_q <= 1'b1;
                    end else if (cnt != CNT_MAX) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_TRACK;
            endcase
        end
    end

    // R2: a detected selection change puts the PLL in holdover next cycle
    a_r2_hold_on_start: assert property (@(posedge clk) disable iff (rst)
        stat.start |=> stat.hold);

    // R5: completion flag only in the first tracking cycle after holdover
    a_r5_done_ends_hold: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!stat.hold && $past(stat.hold)));

    // R10: stored selection frozen while a switch is in progress
    a_r10_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        (stat.hold && !meas_valid) |=> $stable(sel_q));

endmodule

// File: rtl/phr_offset_acc.sv
module phr_offset_acc
    import phr_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int CNT_W = DEF_CNT_W,
    parameter int DLY_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    trig,
    input  logic                    realign,
    input  logic                    meas_valid,
    input  logic [CNT_W-1:0]        meas_ticks,
    output logic signed [ACC_W-1:0] offset,
    output logic [DLY_W-1:0]        delay_use
);

    localparam int OFF_MAX = 2 ** (ACC_W - 1) - 1;
    localparam int BIAS    = OFF_MAX;

    int err;
    int sum;

    always_comb begin
        err       = int'(meas_ticks) - (int'(offset) + BIAS);
        sum       = clamp_sym(int'(offset) + err, OFF_MAX);
        delay_use = DLY_W'(realign ? BIAS : int'(offset) + BIAS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
        end else if (meas_valid) begin
            offset <= realign ? '0 : ACC_W'(sum);
        end else if (trig && realign) begin
            offset <= '0;
        end
    end

    // R4: stored offset stays inside the symmetric saturation range
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (int'(offset) <= OFF_MAX) && (int'(offset) >= -OFF_MAX));

    // R8: realign at an accepted reference pulse leaves a zero offset
    a_r8_realign_clears: assert property (@(posedge clk) disable iff (rst)
        (trig && realign) |=> (offset == '0));

    // R9: a switch completing under realign/slave stores zero
    a_r9_slave_zero: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && realign) |=> (offset == '0));

endmodule

// File: rtl/phr_vref_gen.sv
module phr_vref_gen #(
    parameter int DLY_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             cancel,
    input  logic [DLY_W-1:0] delay,
    output logic             virt
);

    logic             pend;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
            virt <= 1'b0;
        end else if (cancel) begin
            pend <= 1'b0;
            virt <= 1'b0;
        end else if (trig) begin
            pend <= 1'b1;
            cnt  <= delay;
            virt <= 1'b0;
        end else if (pend && cnt == '0) begin
            pend <= 1'b0;
            virt <= 1'b1;
        end else begin
            virt <= 1'b0;
            if (pend) cnt <= cnt - 1'b1;
        end
    end

    // R6: each virtual reference pulse lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        virt |=> !virt);

endmodule

// File: rtl/phase_realign_ctrl.sv
module phase_realign_ctrl
    import phr_pkg::*;
#(
    parameter int N_REF = DEF_N_REF,
    parameter int ACC_W = DEF_ACC_W,
    parameter int CNT_W = DEF_CNT_W,
    parameter int SEL_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REF-1:0]        ref_pulse,
    input  logic [SEL_W-1:0]        ref_sel,
    input  logic                    fb_pulse,
    input  logic                    slave_mode,
    input  logic                    realign_req,
    output logic                    holdover,
    output logic                    virt_ref,
    output logic                    switch_done,
    output logic signed [ACC_W-1:0] phase_offset
);

    localparam int DLY_W = ACC_W + 1;

    seq_status_s      stat;
    logic             sel_edge;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_ticks;
    logic [DLY_W-1:0] delay_use;
    logic             realign;
    logic             trig;

    assign realign = realign_req | slave_mode;
    assign trig    = sel_edge && !stat.hold && !stat.start;

    phr_switch_seq #(.N_REF(N_REF), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ref_sel    (ref_sel),
        .ref_pulse  (ref_pulse),
        .fb_pulse   (fb_pulse),
        .sel_edge   (sel_edge),
        .stat       (stat),
        .meas_valid (meas_valid),
        .meas_ticks (meas_ticks)
    );

    phr_offset_acc #(.ACC_W(ACC_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .realign    (realign),
        .meas_valid (meas_valid),
        .meas_ticks (meas_ticks),
        .offset     (phase_offset),
        .delay_use  (delay_use)
    );

    phr_vref_gen #(.DLY_W(DLY_W)) u_vref (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig),
        .cancel (stat.start),
        .delay  (delay_use),
        .virt   (virt_ref)
    );

    assign holdover    = stat.hold;
    assign switch_done = stat.done;

    // R7: no virtual reference while the PLL is in holdover
    a_r7_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
        holdover |-> !virt_ref);

endmodule

// File: tb/phase_realign_ctrl_tb.sv
module phase_realign_ctrl_tb_top;

    localparam int N_REF = 4;
    localparam int ACC_W = 8;
    localparam int CNT_W = 10;
    localparam int BIAS  = 2 ** (ACC_W - 1) - 1;
    localparam int CMAX  = 2 ** CNT_W - 1;
    localparam int P     = 400;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_REF-1:0]  ref_pulse = '0;
    logic [1:0]        ref_sel = '0;
    logic              fb_pulse = 1'b0;
    logic              slave_mode = 1'b0;
    logic              realign_req = 1'b0;
    logic              holdover;
    logic              virt_ref;
    logic              switch_done;
    logic signed [ACC_W-1:0] phase_offset;

    always #2.5 clk = ~clk;

    phase_realign_ctrl #(.N_REF(N_REF), .ACC_W(ACC_W), .CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ref_pulse    (ref_pulse),
        .ref_sel      (ref_sel),
        .fb_pulse     (fb_pulse),
        .slave_mode   (slave_mode),
        .realign_req  (realign_req),
        .holdover     (holdover),
        .virt_ref     (virt_ref),
        .switch_done  (switch_done),
        .phase_offset (phase_offset)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int bc       = 0;
    int fbph     = 137;
    int ph [N_REF] = '{10, 60, 200, 300};

    // stimulus pulse trains, changed away from the active edge
    always @(negedge clk) begin
        bc <= bc + 1;
        for (int i = 0; i < N_REF; i++) ref_pulse[i] <= ((bc % P) == ph[i]);
        fb_pulse <= ((bc % P) == fbph);
    end

    // behavioural reference model, event times kept as integers
    int m_cyc = 0, m_sel = 0, m_off = 0, m_virt_at = -1, m_t0 = 0;
    bit m_hold = 0, m_wait = 0, m_done = 0, m_virt = 0, started = 0;

    function automatic int clampv(int v);
        if (v > BIAS) return BIAS;
        if (v < -BIAS) return -BIAS;
        return v;
    endfunction

    always @(posedge clk) begin
        bit edge_sel;
        bit ra;
        int c;
        started = 1;
        edge_sel = ref_pulse[m_sel];
        ra = realign_req | slave_mode;
        if (rst) begin
            m_hold = 0; m_wait = 0; m_done = 0; m_virt = 0;
            m_sel = 0; m_off = 0; m_virt_at = -1;
        end else begin
            m_done = 0;
            if (!m_hold) begin
                if (int'(ref_sel) != m_sel) begin
                    m_hold = 1; m_wait = 1; m_sel = int'(ref_sel); m_virt_at = -1;
                end else if (edge_sel) begin
                    if (ra) m_off = 0;
                    m_virt_at = m_cyc + 1 + m_off + BIAS;
                end
            end else if (m_wait) begin
                if (edge_sel) begin m_wait = 0; m_t0 = m_cyc; end
            end else if (fb_pulse) begin
                c = m_cyc - m_t0;
                if (c > CMAX) c = CMAX;
                m_off = ra ? 0 : clampv(m_off + (c - (BIAS + m_off)));
                m_hold = 0; m_done = 1;
            end
            m_virt = (m_cyc == m_virt_at);
        end
        m_cyc++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, m_cyc);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R2", "holdover", int'(holdover), int'(m_hold));
            chk("R6", "virt_ref", int'(virt_ref), int'(m_virt));
            chk("R5", "switch_done", int'(switch_done), int'(m_done));
            chk("R3", "phase_offset", int'(phase_offset), m_off);
            if (holdover) chk("R7", "virt_ref in holdover", int'(virt_ref), 0);
        end
    end

    task automatic wait_done(input string req);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (switch_done) return;
        end
        chk(req, "switch never completed", 0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(4);
        // R1: reset state
        chk("R1", "holdover", int'(holdover), 0);
        chk("R1", "virt_ref", int'(virt_ref), 0);
        chk("R1", "switch_done", int'(switch_done), 0);
        chk("R1", "phase_offset", int'(phase_offset), 0);
        rst = 1'b0;
        idle(3 * P);   // R6: tracking ref 0, unselected inputs ignored

        // R3: switch to ref 1, c = 137-60 = 77 -> offset -50
        ref_sel = 2'd1;
        @(negedge clk);
        chk("R2", "holdover after select", int'(holdover), 1);
        wait_done("R3");
        chk("R5", "holdover low at done", int'(holdover), 0);
        chk("R3", "offset after first switch", int'(phase_offset), -50);
        fbph = 300;
        idle(2 * P);

        // R10: change during holdover deferred; ref 2 gives c = 100 -> -27
        ref_sel = 2'd2;
        @(negedge clk);
        ref_sel = 2'd3;
        wait_done("R10");
        chk("R10", "offset from ref 2", int'(phase_offset), -27);
        @(negedge clk);
        chk("R10", "deferred switch starts", int'(holdover), 1);
        // R11, R4: coincident feedback skipped, c = 400 saturates at +127
        wait_done("R11");
        chk("R11", "coincident fb skipped", int'(phase_offset), 127);
        chk("R4", "positive saturation", int'(phase_offset), BIAS);
        idle(2 * P);

        // R8: level realign request
        realign_req = 1'b1;
        idle(P + 10);
        chk("R8", "offset after realign", int'(phase_offset), 0);
        realign_req = 1'b0;
        idle(P);

        // R9: slave mode forces zero through a switch
        slave_mode = 1'b1;
        ref_sel = 2'd0;
        wait_done("R9");
        chk("R9", "offset after slave switch", int'(phase_offset), 0);
        idle(P);
        chk("R9", "offset held in slave", int'(phase_offset), 0);
        slave_mode = 1'b0;

        // R3: accumulation restarts from zero, c = 300-60 = 240 -> 113
        ref_sel = 2'd1;
        wait_done("R3");
        chk("R3", "offset after clean switch", int'(phase_offset), 113);
        idle(2 * P);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule